// File: doc/BRIEF.md
# Dual-Event Edge Input Capture

This block watches an external input pin and records the value of a free-running counter when a selected transition happens on the pin. The pin is first passed through a synchronizer. The block then classifies each change of the synchronized level as rising or falling and compares it with a 2-bit edge mode. Each qualifying edge stores the counter value in one of two capture slots. The first edge goes into slot one and the second into slot two. After that, edges are ignored until the sequence is rearmed.

A control bit chooses whether the capture event pulse for the interrupt logic fires on the first capture or on the second. Only two things rearm the sequence: a capture-status clear strobe, or a change of the edge mode from none to an active mode. The counter and any register decoding are outside this block. The block receives the counter value, the pin, the mode, the direction bit, the capture-second bit and the clear strobe.

Top module: `cap_edge_capture`

## Requirements
- R1: After reset both capture slots read zero, the event output is low, and the next qualifying edge is stored in slot one.
- R2: The edge mode encodes 0 as none (no capture), 1 as rising (low to high), 2 as falling (high to low) and 3 as both. An edge that the mode does not select changes neither slot and raises no event.
- R3: The direction input must be 1 (pin is an input) for a capture to happen. Edges seen while it is 0 change neither slot and raise no event.
- R4: The first capture after rearm writes slot one and the second writes slot two. Any further edges leave both slots unchanged until rearm.
- R5: A pin change that is present at clock edge k is captured at clock edge k+2. The slot takes the counter value sampled at that edge, and the new value is visible after it.
- R6: When the capture-second input is 0, the event output is a one-cycle pulse in the cycle after the first capture. When it is 1, the pulse follows the second capture only.
- R7: A clear strobe resets the capture sequence, so the next qualifying edge writes slot one again.
- R8: A change of the edge mode from none (0) to any active mode resets the capture sequence.
- R9: If a rearm (R7 or R8) happens at the same clock edge as a qualifying edge, the rearm wins. The edge is dropped, the slots are unchanged and no event is raised.
- R10: The slots change only through captures. A clear or a mode change never alters their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | CNT_W | Free-running counter value |
| pin_i | input | 1 | Asynchronous input pin |
| mode_i | input | 2 | Edge mode: 0 none, 1 rising, 2 falling, 3 both |
| dir_in_i | input | 1 | 1 when the pin is configured as an input |
| cap_second_i | input | 1 | 0: event after first capture, 1: event after second |
| clr_i | input | 1 | Capture-status clear strobe (rearm) |
| slot1_o | output | CNT_W | First capture slot |
| slot2_o | output | CNT_W | Second capture slot |
| event_o | output | 1 | Capture event pulse |

## Verification
On every cycle, the assertions check four things. The slots hold still whenever the mode is none, the pin is an output, a rearm is applied or the sequence is full. The sequence count never passes two. An event never follows a first capture when the event is set for the second. The exact stored counter values, the two-cycle synchronizer latency, the order of the two slots and the rearm-versus-edge priority are shown only by the bench. The bench does this with directed scenarios and a seeded random run compared against a cycle model.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } cap_mode_e;
endpackage

// File: rtl/cap_pin_sync.sv
module cap_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b0;
                end else if (g == 0) begin
                    chain_q[g] <= pin_i;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign prev_o  = prev_q;
endmodule

// File: rtl/cap_edge_qual.sv
module cap_edge_qual
    import cap_pkg::*;
(
    input  cap_mode_e mode_i,
    input  logic      level_i,
    input  logic      prev_i,
    output logic      hit_o
);
    logic rise, fall;

    always_comb begin
        rise = level_i & ~prev_i;
        fall = ~level_i & prev_i;
        unique case (mode_i)
            CAP_RISE: hit_o = rise;
            CAP_FALL: hit_o = fall;
            CAP_BOTH: hit_o = rise | fall;
            default:  hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cap_sequencer.sv
module cap_sequencer
    import cap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             hit_i,
    input  cap_mode_e        mode_i,
    input  logic             dir_in_i,
    input  logic             cap_second_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] slot1_o,
    output logic [CNT_W-1:0] slot2_o,
    output logic             event_o
);
    localparam int SLOTS = 2;
    localparam int IDX_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] slot1;
        logic [CNT_W-1:0] slot2;
        logic             evt;
        cap_mode_e        mode_prev;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       rearm;
    logic       take;

    always_comb begin
        st_d           = st_q;
        st_d.evt       = 1'b0;
        st_d.mode_prev = mode_i;
        rearm = clr_i || (st_q.mode_prev == CAP_OFF && mode_i != CAP_OFF);
        take  = hit_i && dir_in_i && (st_q.idx < IDX_W'(SLOTS)) && !rearm;
        if (rearm) begin
            st_d.idx = '0;
        end else if (take) begin
            if (st_q.idx == '0) st_d.slot1 = count_i;
            else                st_d.slot2 = count_i;
            st_d.evt = (st_q.idx == IDX_W'(cap_second_i));
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{idx: '0, slot1: '0, slot2: '0, evt: 1'b0, mode_prev: CAP_OFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign slot1_o = st_q.slot1;
    assign slot2_o = st_q.slot2;
    assign event_o = st_q.evt;

    // R4: sequence counter never passes the slot count
    p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= IDX_W'(SLOTS));

    // R4: a full sequence leaves both slots alone
    p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx == IDX_W'(SLOTS)) |=> ($stable(slot1_o) && $stable(slot2_o)));

    // R6: no event after the first capture when set for the second
    p_no_early_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cap_second_i && st_q.idx == '0) |=> !event_o);
endmodule

// File: rtl/cap_edge_capture.sv
module cap_edge_capture
    import cap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             pin_i,
    input  logic [1:0]       mode_i,
    input  logic             dir_in_i,
    input  logic             cap_second_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] slot1_o,
    output logic [CNT_W-1:0] slot2_o,
    output logic             event_o
);
    logic      level, prev, hit;
    cap_mode_e mode;

    assign mode = cap_mode_e'(mode_i);

    cap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .level_o (level),
        .prev_o  (prev)
    );

    cap_edge_qual u_qual (
        .mode_i  (mode),
        .level_i (level),
        .prev_i  (prev),
        .hit_o   (hit)
    );

    cap_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .count_i      (count_i),
        .hit_i        (hit),
        .mode_i       (mode),
        .dir_in_i     (dir_in_i),
        .cap_second_i (cap_second_i),
        .clr_i        (clr_i),
        .slot1_o      (slot1_o),
        .slot2_o      (slot2_o),
        .event_o      (event_o)
    );

    // R2: mode none never captures
    p_mode_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0) |=> ($stable(slot1_o) && $stable(slot2_o) && !event_o));

    // R3: pin configured as output never captures
    p_dir_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_in_i |=> ($stable(slot1_o) && $stable(slot2_o) && !event_o));

    // R9 and R10: a clear strobe beats any edge and keeps the slots
    p_clr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ($stable(slot1_o) && $stable(slot2_o) && !event_o));
endmodule

// File: tb/cap_edge_capture_tb.sv
`timescale 1ns/1ps
module cap_edge_capture_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] count_i = '0;
    logic         pin_i = 1'b0;
    logic [1:0]   mode_i = 2'd0;
    logic         dir_in_i = 1'b0;
    logic         cap_second_i = 1'b0;
    logic         clr_i = 1'b0;
    logic [W-1:0] slot1_o, slot2_o;
    logic         event_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    cap_edge_capture #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .pin_i(pin_i),
        .mode_i(mode_i), .dir_in_i(dir_in_i), .cap_second_i(cap_second_i),
        .clr_i(clr_i), .slot1_o(slot1_o), .slot2_o(slot2_o), .event_o(event_o)
    );

    // reference model built from the requirements
    logic         m_s1, m_s2, m_prev, m_evt;
    logic [1:0]   m_mode_q;
    int           m_idx;
    logic [W-1:0] m_c1, m_c2;

    function automatic logic edge_hit(logic [1:0] md, logic old, logic cur);
        case (md)
            2'd1: return !old && cur;
            2'd2: return old && !cur;
            2'd3: return old != cur;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_evt = 0;
            m_mode_q = 0; m_idx = 0; m_c1 = '0; m_c2 = '0;
        end else begin
            logic hit, rearm;
            hit   = edge_hit(mode_i, m_prev, m_s2);
            rearm = clr_i || (m_mode_q == 2'd0 && mode_i != 2'd0);
            m_evt = 0;
            if (rearm) m_idx = 0;
            else if (hit && dir_in_i && m_idx < 2) begin
                if (m_idx == 0) m_c1 = count_i; else m_c2 = count_i;
                m_evt = (m_idx == int'(cap_second_i));
                m_idx++;
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_i; m_mode_q = mode_i;
        end
    end

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Edge applied at a negedge, visible after third following posedge (R5)
    task automatic pin_to(logic v, logic [W-1:0] cval);
        pin_i = v;
        count_i = cval;
        step(3);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 slot1", slot1_o, '0);
        chk("R1 slot2", slot2_o, '0);
        chk("R1 event", {31'b0, event_o}, 0);

        // rising capture into slot one, event on first
        dir_in_i = 1; cap_second_i = 0; mode_i = 2'd1;
        step(1);
        pin_to(1'b1, 32'h0000_1111);
        chk("R5 slot1 value", slot1_o, 32'h0000_1111);
        chk("R6 event on first", {31'b0, event_o}, 1);
        step(1);
        chk("R6 event single cycle", {31'b0, event_o}, 0);

        // falling edge ignored in rising mode
        pin_to(1'b0, 32'h0000_2222);
        chk("R2 falling ignored slot2", slot2_o, '0);
        chk("R2 falling ignored slot1", slot1_o, 32'h0000_1111);

        // event on second, both edges
        cap_second_i = 1; mode_i = 2'd3; clr_i = 1; step(1); clr_i = 0;
        chk("R10 clear keeps slot1", slot1_o, 32'h0000_1111);
        pin_to(1'b1, 32'h0000_3333);
        chk("R7 rearmed to slot1", slot1_o, 32'h0000_3333);
        chk("R6 no event on first", {31'b0, event_o}, 0);
        pin_to(1'b0, 32'h0000_4444);
        chk("R4 second to slot2", slot2_o, 32'h0000_4444);
        chk("R6 event on second", {31'b0, event_o}, 1);
        pin_to(1'b1, 32'h0000_5555);
        chk("R4 third ignored slot1", slot1_o, 32'h0000_3333);
        chk("R4 third ignored slot2", slot2_o, 32'h0000_4444);

        // mode none then active rearms
        mode_i = 2'd0; step(1); mode_i = 2'd2; cap_second_i = 0; step(1);
        pin_to(1'b0, 32'h0000_6666);
        chk("R8 mode rearm slot1", slot1_o, 32'h0000_6666);

        // direction output ignores edges
        clr_i = 1; step(1); clr_i = 0; dir_in_i = 0; mode_i = 2'd3;
        pin_to(1'b1, 32'h0000_7777);
        chk("R3 output dir ignored", slot1_o, 32'h0000_6666);
        chk("R3 no event", {31'b0, event_o}, 0);
        dir_in_i = 1;
        pin_to(1'b0, 32'h0000_8888);
        chk("R3 input dir captures", slot1_o, 32'h0000_8888);

        // clear at the same edge as detection: rearm wins
        pin_i = 1'b1; count_i = 32'h0000_9999;
        step(2);
        clr_i = 1; step(1); clr_i = 0;
        chk("R9 edge dropped slot1", slot1_o, 32'h0000_8888);
        chk("R9 edge dropped slot2", slot2_o, 32'h0000_4444);
        chk("R9 no event", {31'b0, event_o}, 0);
        pin_to(1'b0, 32'h0000_AAAA);
        chk("R9 next edge to slot1", slot1_o, 32'h0000_AAAA);

        // seeded random run against the model
        count_i = 32'hFFFF_FF00;
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 3) == 0) pin_i = ~pin_i;
            if ($urandom_range(0, 40) == 0) mode_i = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 30) == 0) dir_in_i = ~dir_in_i;
            if ($urandom_range(0, 50) == 0) cap_second_i = ~cap_second_i;
            clr_i = ($urandom_range(0, 25) == 0);
            count_i = count_i + 32'd1;
            step(1);
            chk("R4 R5 random slot1", slot1_o, m_c1);
            chk("R4 R5 random slot2", slot2_o, m_c2);
            chk("R6 random event", {31'b0, event_o}, {31'b0, m_evt});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule